// File: doc/BRIEF.md
# Strobe-Controlled FIFO with Retransmit

This block is a first-in first-out buffer with a write port and a read port, each driven by its own active-low strobe. A word is stored when the write strobe is released (rising edge) and the oldest word is presented on the output when the read strobe is asserted (falling edge). The default storage is 2048 words of 9 bits: a byte plus one spare bit that can carry parity or a framing mark. The block never interprets or alters any of the nine bits. The strobes are sampled by one system clock and edge-detected inside the block, so every action lands on a clock edge.

The block runs in one of two modes, chosen by a parameter. In standalone mode it reports full, half-full and empty. A dual-purpose control input then requests a retransmit, which rewinds the read side to the first stored location so the data can be replayed without new writes. In depth-cascade mode several copies share the strobes and data lines, and they pass a write token and a read token around a ring of expansion lines. The dual-purpose input then marks the device that owns both tokens after reset. The half-full pin carries the expansion-out pulse instead of half-full.

Top module: `sfifo_strobe`

## Requirements
- R1: Every word read out equals, in all WIDTH bits (including bit 8 at the default width), the word written, and words leave in the order they were written.
- R2: A write is performed once per strobe, on the rising edge of `wr_n` seen by the clock, capturing `din` at that point.
- R3: A read is performed once per strobe, on the falling edge of `rd_n` seen by the clock; `dout` changes only in the cycle after a read and holds its value otherwise.
- R4: `full` is 1 exactly when DEPTH words are held; a write strobe while full stores nothing and leaves the stored data and the occupancy unchanged.
- R5: `empty` is 1 exactly when no word is held; a read strobe while empty leaves `dout`, the flags and the pointers unchanged.
- R6: In standalone mode `hf_xo` is 1 when more than DEPTH/2 words are held and 0 otherwise.
- R7: While `rst_n` is low (sampled on the clock), both pointers clear, `empty`=1, `full`=0, `hf_xo`=0 in standalone mode and 1 (idle) in cascade mode, and `dout` is 0.
- R8: In standalone mode, `load_rt_n` sampled low while both strobes are high moves the read pointer to location 0 and sets the occupancy to the write pointer value (to DEPTH once the write pointer has wrapped), so flags and later reads follow that occupancy.
- R9: In cascade mode a device acts on a write (read) strobe only while it holds the write (read) token; after reset the device whose `load_rt_n` is low holds both tokens and the others hold none.
- R10: In cascade mode `hf_xo` is an active-low expansion output that pulses low for exactly one cycle after the device writes or reads its last location. It then gives up that token. A device whose `xi_n` is low takes the write token if a write strobe edge occurred on the shared bus in the previous cycle, and it takes the read token if a read strobe edge occurred there.
- R11: A write and a read performed in the same cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples strobes and advances all state |
| rst_n | input | 1 | Active-low reset, sampled on `clk` |
| wr_n | input | 1 | Active-low write strobe; the word is taken when it rises |
| rd_n | input | 1 | Active-low read strobe; the word is presented when it falls |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Read data, held between reads |
| load_rt_n | input | 1 | Standalone: active-low retransmit request. Cascade: active-low first-device select, sampled during reset |
| xi_n | input | 1 | Cascade: active-low expansion input from the previous device; ignored standalone |
| full | output | 1 | High when DEPTH words are held |
| empty | output | 1 | High when no word is held |
| hf_xo | output | 1 | Standalone: half-full (active high). Cascade: expansion-out pulse (active low) |

## Verification
The bench builds one standalone copy with DEPTH=16 and WIDTH=9, so full, half-full and the blocked write at the full boundary are reached in a few dozen strobes. It also builds a two-device ring in cascade mode with DEPTH=8 each, where the first device wraps its write and read pointers after eight words. That brings token hand-over, the one-cycle expansion pulse and the switch of read data from the first device to the second within reach. The ninth bit is set in alternating words to show that it passes through unchanged.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
   // Operating variant selected at elaboration
   typedef enum logic [0:0] {
      SF_STANDALONE = 1'b0,
      SF_CASCADE    = 1'b1
   } sf_mode_e;
endpackage

// File: rtl/sfifo_strobe_sense.sv
module sfifo_strobe_sense #(
   parameter bit ACT_ON_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   output logic evt,
   output logic idle
);
   logic s1_q, s2_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_q <= 1'b1;
         s2_q <= 1'b1;
      end else begin
         s1_q <= strobe_n;
         s2_q <= s1_q;
      end
   end

   generate
      if (ACT_ON_RISE) begin : g_rise
         assign evt = s1_q & ~s2_q;
      end else begin : g_fall
         assign evt = ~s1_q & s2_q;
      end
   endgenerate

   assign idle = s1_q & s2_q;
endmodule

// File: rtl/sfifo_mem.sv
module sfifo_mem #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 2048,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= store[raddr];
   end
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
   import sfifo_pkg::*;
#(
   parameter int       DEPTH = 2048,
   parameter sf_mode_e MODE  = SF_STANDALONE,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_evt,
   input  logic          rd_evt,
   input  logic          wr_idle,
   input  logic          rd_idle,
   input  logic          load_rt_n,
   input  logic          xi_n,
   output logic          we,
   output logic          re,
   output logic [AW-1:0] waddr,
   output logic [AW-1:0] raddr,
   output logic [CW-1:0] occ,
   output logic          full,
   output logic          empty,
   output logic          hf_xo
);
   localparam logic [AW-1:0] LAST_LOC = AW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

   logic [AW-1:0] wp_q, rp_q;
   logic [CW-1:0] occ_q;
   logic          wwrap_q, lrt_q, rt_go, half;
   logic          wtok_q, rtok_q, xo_q;

   assign full  = (occ_q == FULL_CNT);
   assign empty = (occ_q == '0);
   assign half  = (occ_q > HALF_CNT);
   assign we    = wr_evt & ~full  & wtok_q;
   assign re    = rd_evt & ~empty & rtok_q;
   assign rt_go = (MODE == SF_STANDALONE) & lrt_q & wr_idle & rd_idle;

   always_ff @(posedge clk) begin
      if (!rst_n) lrt_q <= 1'b0;
      else        lrt_q <= ~load_rt_n;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q    <= '0;
         rp_q    <= '0;
         occ_q   <= '0;
         wwrap_q <= 1'b0;
      end else if (rt_go) begin
         rp_q  <= '0;
         occ_q <= wwrap_q ? FULL_CNT : {1'b0, wp_q};
      end else begin
         if (we) begin
            wp_q <= wp_q + AW'(1);
            if (wp_q == LAST_LOC) wwrap_q <= 1'b1;
         end
         if (re) rp_q <= rp_q + AW'(1);
         case ({we, re})
            2'b10:   occ_q <= occ_q + CW'(1);
            2'b01:   occ_q <= occ_q - CW'(1);
            default: occ_q <= occ_q;
         endcase
      end
   end

   generate
      if (MODE == SF_CASCADE) begin : g_ring
         logic wr_evt_d, rd_evt_d;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wtok_q   <= ~load_rt_n;
               rtok_q   <= ~load_rt_n;
               xo_q     <= 1'b1;
               wr_evt_d <= 1'b0;
               rd_evt_d <= 1'b0;
            end else begin
               wr_evt_d <= wr_evt;
               rd_evt_d <= rd_evt;
               xo_q     <= ~((we && wp_q == LAST_LOC) || (re && rp_q == LAST_LOC));
               if (we && wp_q == LAST_LOC)    wtok_q <= 1'b0;
               else if (!xi_n && wr_evt_d)    wtok_q <= 1'b1;
               if (re && rp_q == LAST_LOC)    rtok_q <= 1'b0;
               else if (!xi_n && rd_evt_d)    rtok_q <= 1'b1;
            end
         end
      end else begin : g_alone
         logic unused_xi;
         assign unused_xi = xi_n;
         assign wtok_q    = 1'b1;
         assign rtok_q    = 1'b1;
         assign xo_q      = 1'b1;
      end
   endgenerate

   assign hf_xo = (MODE == SF_CASCADE) ? xo_q : half;
   assign waddr = wp_q;
   assign raddr = rp_q;
   assign occ   = occ_q;
endmodule

// File: rtl/sfifo_strobe.sv
module sfifo_strobe
   import sfifo_pkg::*;
#(
   parameter int       WIDTH = 9,
   parameter int       DEPTH = 2048,
   parameter sf_mode_e MODE  = SF_STANDALONE,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_n,
   input  logic             rd_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   input  logic             load_rt_n,
   input  logic             xi_n,
   output logic             full,
   output logic             empty,
   output logic             hf_xo
);
   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sfifo_strobe: DEPTH must be a power of two of at least 4");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("sfifo_strobe: WIDTH must be at least 1");
      end
   endgenerate

   logic          wr_evt, rd_evt, wr_idle, rd_idle, we, re;
   logic [AW-1:0] waddr, raddr;
   logic [CW-1:0] occ;

   sfifo_strobe_sense #(.ACT_ON_RISE(1'b1)) u_wsense (
      .clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .evt(wr_evt), .idle(wr_idle));

   sfifo_strobe_sense #(.ACT_ON_RISE(1'b0)) u_rsense (
      .clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .evt(rd_evt), .idle(rd_idle));

   sfifo_ctrl #(.DEPTH(DEPTH), .MODE(MODE)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr_evt(wr_evt), .rd_evt(rd_evt), .wr_idle(wr_idle), .rd_idle(rd_idle),
      .load_rt_n(load_rt_n), .xi_n(xi_n),
      .we(we), .re(re), .waddr(waddr), .raddr(raddr), .occ(occ),
      .full(full), .empty(empty), .hf_xo(hf_xo));

   sfifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .we(we), .waddr(waddr), .wdata(din),
      .re(re), .raddr(raddr), .rdata(dout));
endmodule

// File: rtl/sfifo_strobe_chk.sv
module sfifo_strobe_chk
   import sfifo_pkg::*;
#(
   parameter int       WIDTH = 9,
   parameter int       DEPTH = 2048,
   parameter sf_mode_e MODE  = SF_STANDALONE,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] dout,
   input logic             full,
   input logic             empty,
   input logic             hf_xo,
   input logic             we,
   input logic             re,
   input logic [CW-1:0]    occ
);
   p_occ_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CW'(DEPTH));

   p_full_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      full && !re |=> full);

   p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

   p_empty_dout_r5: assert property (@(posedge clk) disable iff (!rst_n)
      empty && !we |=> $stable(dout));

   p_dout_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> $stable(dout));

   p_reset_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (empty && !full && occ == '0));

   p_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      we && re |=> $stable(occ));

   generate
      if (MODE == SF_CASCADE) begin : g_casc
         p_xo_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !hf_xo |=> hf_xo);
      end else begin : g_alone
         p_full_implies_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
            full |-> hf_xo);
      end
   endgenerate
endmodule

bind sfifo_strobe sfifo_strobe_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .MODE(MODE)) u_chk (
   .clk(clk), .rst_n(rst_n), .dout(dout), .full(full), .empty(empty),
   .hf_xo(hf_xo), .we(we), .re(re), .occ(occ));

// File: tb/test_sfifo_strobe.sv
module test_sfifo_strobe;
   import sfifo_pkg::*;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   int n_chk = 0;
   int n_err = 0;

   logic       rst_n = 1'b0;
   // standalone copy
   logic       s_wr_n = 1'b1, s_rd_n = 1'b1, s_lrt_n = 1'b1;
   logic [8:0] s_din = '0, s_dout;
   logic       s_full, s_empty, s_hf;
   // cascade ring
   logic       c_wr_n = 1'b1, c_rd_n = 1'b1;
   logic [8:0] c_din = '0, a_dout, b_dout;
   logic       a_full, a_empty, a_xo, b_full, b_empty, b_xo;

   sfifo_strobe #(.WIDTH(9), .DEPTH(16), .MODE(SF_STANDALONE)) i_sfifo_strobe (
      .clk(clk), .rst_n(rst_n), .wr_n(s_wr_n), .rd_n(s_rd_n), .din(s_din),
      .dout(s_dout), .load_rt_n(s_lrt_n), .xi_n(1'b1),
      .full(s_full), .empty(s_empty), .hf_xo(s_hf));

   sfifo_strobe #(.WIDTH(9), .DEPTH(8), .MODE(SF_CASCADE)) i_casc_a (
      .clk(clk), .rst_n(rst_n), .wr_n(c_wr_n), .rd_n(c_rd_n), .din(c_din),
      .dout(a_dout), .load_rt_n(1'b0), .xi_n(b_xo),
      .full(a_full), .empty(a_empty), .hf_xo(a_xo));

   sfifo_strobe #(.WIDTH(9), .DEPTH(8), .MODE(SF_CASCADE)) i_casc_b (
      .clk(clk), .rst_n(rst_n), .wr_n(c_wr_n), .rd_n(c_rd_n), .din(c_din),
      .dout(b_dout), .load_rt_n(1'b1), .xi_n(a_xo),
      .full(b_full), .empty(b_empty), .hf_xo(b_xo));

   // expansion pulse monitor
   int   a_pulses = 0, a_low = 0, b_pulses = 0, b_low = 0;
   logic a_xo_d = 1'b1, b_xo_d = 1'b1;
   always @(negedge clk) begin
      if (!a_xo) a_low++;
      if (!a_xo && a_xo_d) a_pulses++;
      if (!b_xo) b_low++;
      if (!b_xo && b_xo_d) b_pulses++;
      a_xo_d = a_xo;
      b_xo_d = b_xo;
   end

   function automatic logic [8:0] pat(input int i);
      return {i[0], 8'(8'h40 + i * 3)};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      s_wr_n = 1'b1; s_rd_n = 1'b1; s_lrt_n = 1'b1;
      c_wr_n = 1'b1; c_rd_n = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic s_write(input logic [8:0] d);
      @(negedge clk);
      s_din = d; s_wr_n = 1'b0;
      repeat (2) @(negedge clk);
      s_wr_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic s_read(output logic [8:0] d);
      @(negedge clk);
      s_rd_n = 1'b0;
      repeat (3) @(negedge clk);
      d = s_dout;
      s_rd_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic c_write(input logic [8:0] d);
      @(negedge clk);
      c_din = d; c_wr_n = 1'b0;
      repeat (2) @(negedge clk);
      c_wr_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic c_read(output logic [8:0] da, output logic [8:0] db);
      @(negedge clk);
      c_rd_n = 1'b0;
      repeat (3) @(negedge clk);
      da = a_dout; db = b_dout;
      c_rd_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   // R7: reset state, then a reset with data pending clears pointers
   task automatic t_reset();
      logic [8:0] d;
      do_reset();
      check("R7 empty after reset", 32'(s_empty), 32'd1);
      check("R7 full after reset", 32'(s_full), 32'd0);
      check("R7 half after reset", 32'(s_hf), 32'd0);
      check("R7 dout after reset", 32'(s_dout), 32'd0);
      check("R7 cascade xo idle", 32'({a_xo, b_xo}), 32'd3);
      s_write(9'h011); s_write(9'h122); s_write(9'h033);
      do_reset();
      check("R7 empty after reset with data", 32'(s_empty), 32'd1);
      s_write(9'h1C5);
      s_read(d);
      check("R7 pointers cleared", 32'(d), 32'h1C5);
   endtask

   // R1 R2 R3: order and nine-bit integrity
   task automatic t_basic();
      logic [8:0] d;
      do_reset();
      for (int i = 0; i < 4; i++) s_write(pat(i));
      check("R2 not empty after writes", 32'(s_empty), 32'd0);
      for (int i = 0; i < 4; i++) begin
         s_read(d);
         check("R1 R3 read order and data", 32'(d), 32'(pat(i)));
      end
      check("R5 empty after draining", 32'(s_empty), 32'd1);
   endtask

   // R5: read while empty changes nothing
   task automatic t_empty_read();
      logic [8:0] d;
      d = s_dout;
      s_read(d);
      check("R5 dout unchanged on empty read", 32'(s_dout), 32'(pat(3)));
      check("R5 still empty", 32'(s_empty), 32'd1);
      s_write(9'h0AA);
      s_read(d);
      check("R5 pointers unchanged by empty read", 32'(d), 32'h0AA);
   endtask

   // R4 R6: fill to the boundary, blocked write
   task automatic t_fill();
      logic [8:0] d;
      do_reset();
      for (int i = 0; i < 8; i++) s_write(pat(i + 10));
      check("R6 half low at DEPTH/2", 32'(s_hf), 32'd0);
      s_write(pat(18));
      check("R6 half high above DEPTH/2", 32'(s_hf), 32'd1);
      for (int i = 9; i < 15; i++) s_write(pat(i + 10));
      check("R4 not full at DEPTH-1", 32'(s_full), 32'd0);
      s_write(pat(25));
      check("R4 full at DEPTH", 32'(s_full), 32'd1);
      s_write(9'h1FF);
      check("R4 full after blocked write", 32'(s_full), 32'd1);
      for (int i = 0; i < 16; i++) begin
         s_read(d);
         check("R4 data intact after blocked write", 32'(d), 32'(pat(i + 10)));
      end
      check("R4 empty after 16 reads, blocked word absent", 32'(s_empty), 32'd1);
      check("R6 half low when empty", 32'(s_hf), 32'd0);
   endtask

   // R8: retransmit replays from location 0
   task automatic t_retransmit();
      logic [8:0] d;
      do_reset();
      for (int i = 0; i < 5; i++) s_write(pat(i + 30));
      s_read(d);
      s_read(d);
      check("R8 pre-retransmit second word", 32'(d), 32'(pat(31)));
      @(negedge clk);
      s_lrt_n = 1'b0;
      repeat (2) @(negedge clk);
      s_lrt_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R8 empty low after retransmit", 32'(s_empty), 32'd0);
      check("R8 half low with five words", 32'(s_hf), 32'd0);
      for (int i = 0; i < 5; i++) begin
         s_read(d);
         check("R8 replayed word", 32'(d), 32'(pat(i + 30)));
      end
      check("R8 empty after replay", 32'(s_empty), 32'd1);
   endtask

   // R11: write and read in the same cycle
   task automatic t_same_cycle();
      logic [8:0] d;
      do_reset();
      s_write(pat(40)); s_write(pat(41));
      @(negedge clk);
      s_din = pat(42); s_wr_n = 1'b0;
      repeat (2) @(negedge clk);
      s_wr_n = 1'b1; s_rd_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R11 read in shared cycle", 32'(s_dout), 32'(pat(40)));
      s_rd_n = 1'b1;
      repeat (2) @(negedge clk);
      s_read(d);
      check("R11 second word", 32'(d), 32'(pat(41)));
      s_read(d);
      check("R11 word written in shared cycle", 32'(d), 32'(pat(42)));
      check("R11 occupancy unchanged, now empty", 32'(s_empty), 32'd1);
   endtask

   // R9 R10: two-device ring
   task automatic t_cascade();
      logic [8:0] da, db;
      int pa, la, pb;
      do_reset();
      pa = a_pulses; la = a_low; pb = b_pulses;
      c_write(pat(50));
      check("R9 first device takes first write", 32'(a_empty), 32'd0);
      check("R9 second device without token ignores write", 32'(b_empty), 32'd1);
      for (int i = 1; i < 8; i++) c_write(pat(50 + i));
      check("R9 first device full", 32'(a_full), 32'd1);
      check("R9 second device still empty", 32'(b_empty), 32'd1);
      check("R10 one write-wrap pulse", 32'(a_pulses - pa), 32'd1);
      check("R10 pulse lasts one cycle", 32'(a_low - la), 32'd1);
      for (int i = 8; i < 12; i++) c_write(pat(50 + i));
      check("R10 write token moved to second device", 32'(b_empty), 32'd0);
      check("R10 first device unchanged", 32'(a_full), 32'd1);
      for (int i = 0; i < 12; i++) begin
         c_read(da, db);
         if (i < 8) check("R1 R9 read from first device", 32'(da), 32'(pat(50 + i)));
         else       check("R1 R10 read from second device", 32'(db), 32'(pat(50 + i)));
      end
      check("R10 two pulses from first device", 32'(a_pulses - pa), 32'd2);
      check("R10 no pulse from second device", 32'(b_pulses - pb), 32'd0);
      check("R9 both drained", 32'({a_empty, b_empty}), 32'd3);
   endtask

   task automatic run_all();
      t_reset();
      t_basic();
      t_empty_read();
      t_fill();
      t_retransmit();
      t_same_cycle();
      t_cascade();
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual 1 expected 0");
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule